// File: doc/BRIEF.md
# Split-Word Register File Access Port

This block holds a bank of 64-bit registers. Software reaches them 32 bits at a time through a 12-bit command word. Bit 0 of the command picks the half: 0 selects the upper (MSW) half and 1 selects the lower (LSW) half. A register is addressed in one of three ways:

- by a 5-bit field carried in the command;
- by a 3-bit field that reaches only the first eight registers;
- by a separately written load pointer.

A refresh command walks eight consecutive registers, starting at the load pointer. For each register it copies the upper half out to a temporary register and writes it back, then does the same for the lower half. The walk takes four cycles per register.

Commands arrive on a valid/ready stream. `cmd_ready` is high whenever no refresh is running, so a command is accepted on any rising edge where both `cmd_valid` and `cmd_ready` are high. While a refresh runs, `cmd_ready` stays low. The sender must then hold its command, and the block takes it once the walk has finished. The read result is a registered output with a one-cycle `rd_valid` strobe and no back-pressure. The load pointer is a plain write port that is always accepted.

Top module: `regfile_split_port`

## Requirements
- R1: After reset, every register half reads 0, the load pointer is 0, `rd_valid`, `done` and `busy` are low, and `cmd_ready` is high.
- R2: An accepted command `101100_aaaaa_h` reads half `h` of register `aaaaa` (command bits 5:1). `rd_data` holds that half, with `rd_valid` high, in the cycle after acceptance.
- R3: An accepted command `001100_aaaaa_h` writes `cmd_wdata` into half `h` of register `aaaaa` (command bits 5:1).
- R4: A write to one half of a register leaves the other half of that register, and every other register, unchanged.
- R5: Commands `1011101000_x_h` read and `0011101000_x_h` write half `h` of the register selected by the load pointer. Command bit 1 has no effect.
- R6: When `lp_we` is high at a rising edge, `lp_wdata` is stored as the 5-bit load pointer. A command accepted at that same edge uses the previous pointer value.
- R7: An accepted command `00111000_sss_h` writes `cmd_wdata` into half `h` of register `sss` (bits 3:1, registers 0 to 7).
- R8: The command `001001110001` starts a refresh. `busy` is high for exactly 32 cycles. During that time it touches the eight registers starting at the load pointer, wrapping modulo 32, and leaves every register value unchanged. `done` pulses for one cycle as `busy` falls.
- R9: While `busy` is high, `cmd_ready` is low and no command is accepted, so a command presented in that time has no effect.
- R10: `done` pulses for one cycle after each accepted read or write command. Any other command code is accepted with no effect and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low during refresh) |
| cmd_op | input | 12 | Command code |
| cmd_wdata | input | 32 | Write data for write commands |
| lp_we | input | 1 | Load-pointer write enable |
| lp_wdata | input | 5 | New load-pointer value |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Refresh in progress |

## Verification
The assertions take for granted that reset is applied before the first command and that `cmd_op`, `cmd_wdata` and `lp_wdata` are known whenever their enable or valid is high. The write-back check during a refresh also relies on no write coming from outside while `busy` is high. The bench keeps within these limits by driving every input from the falling edge with defined values. During a refresh it holds a write command on the stream and withdraws it the moment `cmd_ready` returns, so that command is never accepted.

// File: rtl/rfsp_pkg.sv
package rfsp_pkg;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2,
    CK_SWEEP = 2'd3
  } cmd_kind_e;

endpackage

// File: rtl/rfsp_decode.sv
module rfsp_decode
  import rfsp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [11:0]   op,
  input  logic [AW-1:0] lptr,
  output cmd_kind_e     kind,
  output logic [AW-1:0] addr,
  output logic          lo_half
);

  localparam int SHW = 3;

  always_comb begin
    kind    = CK_NONE;
    addr    = '0;
    lo_half = op[0];
    if (op[11:6] == 6'b101100) begin
      kind = CK_READ;
      addr = AW'(op[5:1]);
    end else if (op[11:6] == 6'b001100) begin
      kind = CK_WRITE;
      addr = AW'(op[5:1]);
    end else if (op[11:2] == 10'b1011101000) begin
      kind = CK_READ;
      addr = lptr;
    end else if (op[11:2] == 10'b0011101000) begin
      kind = CK_WRITE;
      addr = lptr;
    end else if (op[11:4] == 8'b00111000) begin
      kind = CK_WRITE;
      addr = AW'(op[SHW:1]);
    end else if (op == 12'b001001110001) begin
      kind = CK_SWEEP;
    end
  end

endmodule

// File: rtl/rfsp_bank.sv
module rfsp_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rd_hi,
  output logic [DATA_W-1:0] rd_lo
);

  localparam int NREG = 1 << AW;

  logic [DATA_W-1:0] hi_q [NREG];
  logic [DATA_W-1:0] lo_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else begin
        if (we_hi && waddr == AW'(g)) hi_q[g] <= wdata;
        if (we_lo && waddr == AW'(g)) lo_q[g] <= wdata;
      end
    end
  end

  assign rd_hi = hi_q[raddr];
  assign rd_lo = lo_q[raddr];

  // R4: an upper-half write keeps the lower half of the same register
  a_r4_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !we_lo) |=> lo_q[$past(waddr)] == $past(lo_q[waddr]));

  // R4: a lower-half write keeps the upper half of the same register
  a_r4_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |=> hi_q[$past(waddr)] == $past(hi_q[waddr]));

endmodule

// File: rtl/rfsp_sweep.sv
module rfsp_sweep #(
  parameter int DATA_W  = 32,
  parameter int AW      = 5,
  parameter int SWEEP_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_ptr,
  input  logic [DATA_W-1:0] rd_hi,
  input  logic [DATA_W-1:0] rd_lo,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     acc_addr,
  output logic              we_hi,
  output logic              we_lo,
  output logic [DATA_W-1:0] wdata
);

  localparam int STEPS = SWEEP_N * 4;
  localparam int CW    = $clog2(STEPS);

  logic [CW-1:0]     step_q;
  logic [AW-1:0]     ptr_q;
  logic [DATA_W-1:0] tmp_q;
  logic              busy_q, done_q;
  logic [1:0]        phase;

  assign phase = step_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      ptr_q  <= '0;
      tmp_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        step_q <= '0;
        ptr_q  <= start_ptr;
      end else if (busy_q) begin
        case (phase)
          2'd0:    tmp_q <= rd_hi;
          2'd2:    tmp_q <= rd_lo;
          2'd3:    ptr_q <= ptr_q + 1'b1;
          default: ;
        endcase
        if (step_q == CW'(STEPS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign acc_addr = ptr_q;
  assign we_hi    = busy_q && phase == 2'd1;
  assign we_lo    = busy_q && phase == 2'd3;
  assign wdata    = tmp_q;

  // R8: an accepted refresh raises busy on the next cycle
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R8: the completion strobe lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the value written back is the one copied out a cycle earlier
  a_r8_hi_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |-> tmp_q == $past(rd_hi));

  a_r8_lo_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |-> tmp_q == $past(rd_lo));

endmodule

// File: rtl/regfile_split_port.sv
module regfile_split_port
  import rfsp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AW      = 5,
  parameter int SWEEP_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [11:0]       cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              lp_we,
  input  logic [AW-1:0]     lp_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              busy
);

  logic [AW-1:0]     lptr_q;
  cmd_kind_e         kind;
  logic [AW-1:0]     dec_addr;
  logic              dec_lo;
  logic              accept, cmd_we, cmd_rd, sw_start;
  logic              sw_busy, sw_done, sw_we_hi, sw_we_lo;
  logic [AW-1:0]     sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic              bk_we_hi, bk_we_lo;
  logic [AW-1:0]     bk_waddr, bk_raddr;
  logic [DATA_W-1:0] bk_wdata, bk_rd_hi, bk_rd_lo;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q, cmd_done_q;

  rfsp_decode #(.AW(AW)) u_dec (
    .op      (cmd_op),
    .lptr    (lptr_q),
    .kind    (kind),
    .addr    (dec_addr),
    .lo_half (dec_lo)
  );

  assign cmd_ready = !sw_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_we    = accept && kind == CK_WRITE;
  assign cmd_rd    = accept && kind == CK_READ;
  assign sw_start  = accept && kind == CK_SWEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lptr_q <= '0;
    else if (lp_we) lptr_q <= lp_wdata;
  end

  rfsp_sweep #(.DATA_W(DATA_W), .AW(AW), .SWEEP_N(SWEEP_N)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sw_start),
    .start_ptr (lptr_q),
    .rd_hi     (bk_rd_hi),
    .rd_lo     (bk_rd_lo),
    .busy      (sw_busy),
    .done      (sw_done),
    .acc_addr  (sw_addr),
    .we_hi     (sw_we_hi),
    .we_lo     (sw_we_lo),
    .wdata     (sw_wdata)
  );

  assign bk_we_hi = sw_busy ? sw_we_hi : (cmd_we && !dec_lo);
  assign bk_we_lo = sw_busy ? sw_we_lo : (cmd_we && dec_lo);
  assign bk_waddr = sw_busy ? sw_addr  : dec_addr;
  assign bk_raddr = sw_busy ? sw_addr  : dec_addr;
  assign bk_wdata = sw_busy ? sw_wdata : cmd_wdata;

  rfsp_bank #(.DATA_W(DATA_W), .AW(AW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we_hi (bk_we_hi),
    .we_lo (bk_we_lo),
    .waddr (bk_waddr),
    .wdata (bk_wdata),
    .raddr (bk_raddr),
    .rd_hi (bk_rd_hi),
    .rd_lo (bk_rd_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      cmd_done_q <= 1'b0;
    end else begin
      rd_valid_q <= cmd_rd;
      cmd_done_q <= cmd_rd || cmd_we;
      if (cmd_rd) rd_data_q <= dec_lo ? bk_rd_lo : bk_rd_hi;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign done     = cmd_done_q || sw_done;
  assign busy     = sw_busy;

  // R9: no command write reaches the bank during a refresh
  a_r9_no_cmd_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sw_busy |-> !cmd_we);

  // R2: read strobe only follows an accepted read
  a_r2_rdv_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(cmd_rd));

  // R10: command completion and refresh completion never coincide
  a_r10_done_sources: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done_q && sw_done));

endmodule

// File: tb/test_regfile_split_port.sv
module test_regfile_split_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [11:0] cmd_op = '0;
  logic [31:0] cmd_wdata = '0;
  logic        lp_we = 1'b0;
  logic [4:0]  lp_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, done, busy;

  regfile_split_port i_regfile_split_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .lp_we(lp_we), .lp_wdata(lp_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .busy(busy)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_hi [32];
  logic [31:0] m_lo [32];
  logic [4:0]  m_lp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] mread(input logic [4:0] a, input logic lo);
    return lo ? m_lo[a] : m_hi[a];
  endfunction

  // Issue one command; optionally load the pointer at the same edge.
  task automatic issue(input logic [11:0] op, input logic [31:0] wd,
                       input logic setlp, input logic [4:0] lpv,
                       output logic rv, output logic dn, output logic [31:0] rd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
    lp_we = setlp; lp_wdata = lpv;
    @(negedge clk);
    cmd_valid = 1'b0; lp_we = 1'b0;
    rv = rd_valid; dn = done; rd = rd_data;
  endtask

  task automatic rd_imm(input logic [4:0] a, input logic lo, input string req);
    logic rv, dn; logic [31:0] rd;
    issue({6'b101100, a, lo}, 32'h0, 1'b0, 5'd0, rv, dn, rd);
    chk({req, " rd_valid"}, 32'(rv), 32'd1);
    chk({req, " data"}, rd, mread(a, lo));
  endtask

  task automatic wr_imm(input logic [4:0] a, input logic lo, input logic [31:0] d, input string req);
    logic rv, dn; logic [31:0] rd;
    issue({6'b001100, a, lo}, d, 1'b0, 5'd0, rv, dn, rd);
    if (lo) m_lo[a] = d; else m_hi[a] = d;
    chk({req, " done after write"}, 32'(dn), 32'd1);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 32; a++) begin
      rd_imm(5'(a), 1'b0, req);
      rd_imm(5'(a), 1'b1, req);
    end
  endtask

  task automatic run_sweep(input string req);
    logic rv, dn; logic [31:0] rd;
    int n;
    issue(12'b001001110001, 32'h0, 1'b0, 5'd0, rv, dn, rd);
    n = 0;
    // hold a write to register 31 on the stream while busy (R9)
    cmd_valid = 1'b1; cmd_op = {6'b001100, 5'd31, 1'b0}; cmd_wdata = 32'hDEAD_BEEF;
    while (!cmd_ready && n < 100) begin
      n++;
      chk({req, " R8 busy high"}, 32'(busy), 32'd1);
      chk({req, " R8 no early done"}, 32'(done), 32'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk({req, " R8 busy length"}, 32'(n), 32'd32);
    chk({req, " R8 done at end"}, 32'(done), 32'd1);
    chk({req, " R8 busy low"}, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    logic rv, dn; logic [31:0] rd;
    void'($urandom(32'd2024));
    for (int a = 0; a < 32; a++) begin m_hi[a] = '0; m_lo[a] = '0; end
    m_lp = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid after release", 32'(rd_valid), 32'd0);
    rd_imm(5'd7, 1'b0, "R1 zero");
    rd_imm(5'd31, 1'b1, "R1 zero");
    // R1 pointer is 0: pointer read of register 0
    issue(12'b101110100000, 32'h0, 1'b0, 5'd0, rv, dn, rd);
    chk("R1 R5 pointer reset", rd, 32'h0);

    // R2 R3 R4 directed
    wr_imm(5'd3, 1'b0, 32'hAAAA_0003, "R3");
    rd_imm(5'd3, 1'b0, "R2 upper");
    rd_imm(5'd3, 1'b1, "R4 lower kept");
    wr_imm(5'd3, 1'b1, 32'h5555_1003, "R3");
    rd_imm(5'd3, 1'b0, "R4 upper kept");
    rd_imm(5'd3, 1'b1, "R2 lower");

    // R6: pointer write and pointer command at the same edge use old pointer
    issue(12'b001110100000, 32'h1111_2222, 1'b1, 5'd9, rv, dn, rd);
    m_hi[m_lp] = 32'h1111_2222; m_lp = 5'd9;
    rd_imm(5'd0, 1'b0, "R6 old pointer used");
    rd_imm(5'd9, 1'b0, "R6 new pointer not yet used");
    // R5: pointer read/write, bit 1 ignored
    issue(12'b001110100011, 32'h3333_4444, 1'b0, 5'd0, rv, dn, rd);
    m_lo[m_lp] = 32'h3333_4444;
    chk("R5 done", 32'(dn), 32'd1);
    issue(12'b101110100001, 32'h0, 1'b0, 5'd0, rv, dn, rd);
    chk("R5 pointer read", rd, m_lo[9]);
    // R7 shadow write
    issue({8'b00111000, 3'd5, 1'b1}, 32'h7777_0005, 1'b0, 5'd0, rv, dn, rd);
    m_lo[5] = 32'h7777_0005;
    chk("R7 done", 32'(dn), 32'd1);
    rd_imm(5'd5, 1'b1, "R7 shadow");
    rd_imm(5'd5, 1'b0, "R7 other half");
    // R10 unknown code: no done, no effect
    issue(12'h000, 32'hFFFF_FFFF, 1'b0, 5'd0, rv, dn, rd);
    chk("R10 no done", 32'(dn), 32'd0);
    chk("R10 no rd_valid", 32'(rv), 32'd0);
    issue(12'b101111000000, 32'hFFFF_FFFF, 1'b0, 5'd0, rv, dn, rd);
    chk("R10 no done 2", 32'(dn), 32'd0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int c = $urandom % 6;
      logic [4:0] a = 5'($urandom);
      logic lo = 1'($urandom);
      logic [31:0] d = $urandom;
      case (c)
        0: rd_imm(a, lo, "R2 random");
        1: wr_imm(a, lo, d, "R3 random");
        2: begin
          issue({10'b1011101000, 1'($urandom), lo}, 32'h0, 1'b0, 5'd0, rv, dn, rd);
          chk("R5 random read", rd, mread(m_lp, lo));
        end
        3: begin
          issue({10'b0011101000, 1'($urandom), lo}, d, 1'b0, 5'd0, rv, dn, rd);
          if (lo) m_lo[m_lp] = d; else m_hi[m_lp] = d;
        end
        4: begin
          issue({8'b00111000, a[2:0], lo}, d, 1'b0, 5'd0, rv, dn, rd);
          if (lo) m_lo[{2'b0, a[2:0]}] = d; else m_hi[{2'b0, a[2:0]}] = d;
        end
        default: begin
          @(negedge clk); lp_we = 1'b1; lp_wdata = a;
          @(negedge clk); lp_we = 1'b0; m_lp = a;
        end
      endcase
    end

    // R8 refresh with wrap: pointer 28 covers 28..31, 0..3
    @(negedge clk); lp_we = 1'b1; lp_wdata = 5'd28;
    @(negedge clk); lp_we = 1'b0; m_lp = 5'd28;
    run_sweep("R8 wrap");
    check_all("R8 R9 contents kept");
    @(negedge clk); lp_we = 1'b1; lp_wdata = 5'd2;
    @(negedge clk); lp_we = 1'b0; m_lp = 5'd2;
    run_sweep("R8 second");
    check_all("R8 R9 contents kept 2");
    wrap_up();
  end

endmodule